// File: doc/BRIEF.md
# Receive Sample Capture Queue

This block sits on the host side of a serial codec link, after the deframer. Each time a frame has been decoded, it gets a one-cycle strobe together with the 16-bit sample word and the frame's sample-valid flag. It decides whether that sample is new and, if it is, writes it into an eight-entry first-in first-out queue that software drains through a simple read port.

There are two capture policies.

- **Valid-flag policy:** the frame's own valid flag decides every capture.
- **Rate-tick policy:** the valid flag decides only the first capture after the channel is enabled. After that, the flag is ignored. A local sample-rate tick marks that a fresh conversion will be in the next completed frame.

Capture only happens while the channel enable bit is high. The queue reports its fill level, full and empty. It also keeps sticky overrun and underrun flags, and each flag is cleared by a write-one-to-clear pulse.

Top module: `smp_rx_capture`

## Requirements
- R1: After reset the queue is empty, `level` is 0, `full`, `overrun` and `underrun` are 0, and `rd_data` is 0.
- R2: With `mode_sel`=0 (valid-flag policy) and the channel enabled, a `frm_done` strobe with `frm_valid`=1 stores `frm_sample`. A strobe with `frm_valid`=0 stores nothing.
- R3: While `chan_en`=0, no sample is stored and rate ticks are forgotten. Dropping `chan_en` also clears the record that a first sample was stored, so the next rate-tick capture again needs `frm_valid`=1.
- R4: With `mode_sel`=1 (rate-tick policy), until a first sample has been stored since enable, a strobe captures only when `frm_valid`=1. Rate ticks in that phase are ignored.
- R5: With `mode_sel`=1, after the first stored sample `frm_valid` is ignored. A strobe captures only if a `rate_tick` arrived in the same cycle or at any time since the previous strobe. Several ticks before one strobe give one capture.
- R6: The queue holds 8 samples and returns them in arrival order. `level` runs from 0 to 8, with `full` at 8 and `empty` at 0. `rd_data` shows the popped word in the cycle after `rd_en` is sampled.
- R7: A capture attempted while `full`=1 is dropped, leaves the stored data and `level` unchanged, and sets `overrun`. `overrun` stays set until an `ovr_clr` pulse. If a drop and a clear happen in the same cycle, the flag stays set.
- R8: `rd_en` while empty leaves `rd_data` at its last value and sets `underrun`. The flag stays set until an `udr_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_done | input | 1 | One-cycle strobe: a frame has been decoded |
| frm_sample | input | 16 | Sample word carried by that frame |
| frm_valid | input | 1 | Sample-valid flag carried by that frame |
| chan_en | input | 1 | Channel enable status bit |
| mode_sel | input | 1 | 0 = valid-flag policy, 1 = rate-tick policy |
| rate_tick | input | 1 | Local sample-rate counter expiry pulse |
| rd_en | input | 1 | Pop one entry |
| ovr_clr | input | 1 | Write-one-to-clear for `overrun` |
| udr_clr | input | 1 | Write-one-to-clear for `underrun` |
| rd_data | output | 16 | Last popped sample |
| level | output | 4 | Number of stored samples, 0 to 8 |
| empty | output | 1 | Queue holds nothing |
| full | output | 1 | Queue holds 8 samples |
| overrun | output | 1 | Sticky: a capture was dropped |
| underrun | output | 1 | Sticky: an empty queue was read |

## Verification
The bench mixes the two sources of a capture in the rate-tick policy:
- a frame carrying a valid flag but no tick, which a design still trusting the flag would store;
- ticks that come before the first stored sample, which a design counting too early would turn into a spurious capture;
- two ticks before one frame, which a level-sensitive design would store twice;
- a tick in the same cycle as the strobe, which a design that only looks at earlier ticks would miss.

Disabling and re-enabling the channel must bring back the valid-flag gate for the first sample. The boundary cases matter as much:
- A ninth capture must vanish without overwriting the oldest entry.
- A drop in the same cycle as a clear must leave `overrun` set.
- An empty read must leave `rd_data` unchanged rather than show a stale memory slot.

// File: rtl/rxcap_pkg.sv
package rxcap_pkg;

  typedef enum logic {
    CAP_VALID = 1'b0,
    CAP_RATE  = 1'b1
  } cap_mode_e;

  // next pointer value with wrap at an arbitrary depth
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // occupancy after one cycle of push/pop
  function automatic int unsigned level_next(input int unsigned lvl, input logic up, input logic dn);
    return lvl + (up ? 1 : 0) - (dn ? 1 : 0);
  endfunction

endpackage

// File: rtl/rxcap_sticky.sv
module rxcap_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/rxcap_policy.sv
module rxcap_policy
  import rxcap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      chan_en,
  input  cap_mode_e mode,
  input  logic      frm_done,
  input  logic      frm_valid,
  input  logic      rate_tick,
  input  logic      push_ok,
  output logic      push_req
);
  logic first_q;   // a sample has been stored since enable
  logic pend_q;    // rate tick seen since last strobe
  logic by_rate;   // rate-tick policy is in its counting phase

  assign by_rate = (mode == CAP_RATE) && first_q;

  always_comb begin
    push_req = 1'b0;
    if (chan_en && frm_done) begin
      if (by_rate) push_req = pend_q | rate_tick;
      else         push_req = frm_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (!chan_en) begin
      first_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (push_ok) first_q <= 1'b1;
      if (!by_rate)       pend_q <= 1'b0;
      else if (frm_done)  pend_q <= 1'b0;
      else if (rate_tick) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rxcap_fifo.sv
module rxcap_fifo
  import rxcap_pkg::*;
#(
  parameter int W = 16,
  parameter int D = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [W-1:0]             din,
  input  logic                     pop,
  output logic [W-1:0]             dout,
  output logic [$clog2(D+1)-1:0]   level,
  output logic                     full,
  output logic                     empty,
  output logic                     push_ok,
  output logic                     push_drop,
  output logic                     pop_ok,
  output logic                     pop_empty
);
  localparam int AW = (D > 1) ? $clog2(D) : 1;
  localparam int LW = $clog2(D + 1);

  logic [W-1:0]  mem [D];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;

  assign full      = (cnt == LW'(D));
  assign empty     = (cnt == '0);
  assign push_ok   = push & ~full;
  assign push_drop = push & full;
  assign pop_ok    = pop & ~empty;
  assign pop_empty = pop & empty;
  assign level     = cnt;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      dout <= '0;
    end else begin
      if (push_ok) wptr <= AW'(ptr_next(32'(wptr), D));
      if (pop_ok) begin
        dout <= mem[rptr];
        rptr <= AW'(ptr_next(32'(rptr), D));
      end
      cnt <= LW'(level_next(32'(cnt), push_ok, pop_ok));
    end
  end
endmodule

// File: rtl/smp_rx_capture.sv
module smp_rx_capture
  import rxcap_pkg::*;
#(
  parameter int W = 16,
  parameter int D = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frm_done,
  input  logic [W-1:0]           frm_sample,
  input  logic                   frm_valid,
  input  logic                   chan_en,
  input  logic                   mode_sel,
  input  logic                   rate_tick,
  input  logic                   rd_en,
  input  logic                   ovr_clr,
  input  logic                   udr_clr,
  output logic [W-1:0]           rd_data,
  output logic [$clog2(D+1)-1:0] level,
  output logic                   empty,
  output logic                   full,
  output logic                   overrun,
  output logic                   underrun
);
  // named internal events, observed by the bound checker
  logic push_req, push_ok, push_drop, pop_ok, pop_empty;

  rxcap_policy u_policy (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .mode      (cap_mode_e'(mode_sel)),
    .frm_done  (frm_done),
    .frm_valid (frm_valid),
    .rate_tick (rate_tick),
    .push_ok   (push_ok),
    .push_req  (push_req)
  );

  rxcap_fifo #(.W(W), .D(D)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_req),
    .din       (frm_sample),
    .pop       (rd_en),
    .dout      (rd_data),
    .level     (level),
    .full      (full),
    .empty     (empty),
    .push_ok   (push_ok),
    .push_drop (push_drop),
    .pop_ok    (pop_ok),
    .pop_empty (pop_empty)
  );

  rxcap_sticky u_ovr (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (push_drop),
    .clr_i (ovr_clr),
    .q_o   (overrun)
  );

  rxcap_sticky u_udr (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (pop_empty),
    .clr_i (udr_clr),
    .q_o   (underrun)
  );
endmodule

// File: rtl/smp_rx_capture_chk.sv
module smp_rx_capture_chk #(
  parameter int W = 16,
  parameter int D = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   chan_en,
  input logic                   mode_sel,
  input logic                   frm_done,
  input logic                   frm_valid,
  input logic [W-1:0]           rd_data,
  input logic [$clog2(D+1)-1:0] level,
  input logic                   full,
  input logic                   empty,
  input logic                   overrun,
  input logic                   underrun,
  input logic                   push_req,
  input logic                   push_ok,
  input logic                   push_drop,
  input logic                   pop_ok,
  input logic                   pop_empty
);
  localparam int LW = $clog2(D + 1);

  p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(D));

  p_full_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (level == LW'(D)));

  p_empty_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (level == '0));

  p_level_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (level == $past(level) + 1'b1));

  p_no_capture_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !push_req);

  p_valid_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && frm_done && !frm_valid) |-> !push_req);

  p_drop_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> overrun);

  p_drop_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop_ok) |=> (level == $past(level)));

  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_empty |=> (underrun && $stable(rd_data)));
endmodule

bind smp_rx_capture smp_rx_capture_chk #(.W(W), .D(D)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_en   (chan_en),
  .mode_sel  (mode_sel),
  .frm_done  (frm_done),
  .frm_valid (frm_valid),
  .rd_data   (rd_data),
  .level     (level),
  .full      (full),
  .empty     (empty),
  .overrun   (overrun),
  .underrun  (underrun),
  .push_req  (push_req),
  .push_ok   (push_ok),
  .push_drop (push_drop),
  .pop_ok    (pop_ok),
  .pop_empty (pop_empty)
);

// File: tb/test_smp_rx_capture.sv
module test_smp_rx_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frm_done, frm_valid, chan_en, mode_sel, rate_tick;
  logic        rd_en, ovr_clr, udr_clr;
  logic [15:0] frm_sample;
  logic [15:0] rd_data;
  logic [3:0]  level;
  logic        empty, full, overrun, underrun;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  smp_rx_capture i_smp_rx_capture (
    .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_sample(frm_sample),
    .frm_valid(frm_valid), .chan_en(chan_en), .mode_sel(mode_sel),
    .rate_tick(rate_tick), .rd_en(rd_en), .ovr_clr(ovr_clr), .udr_clr(udr_clr),
    .rd_data(rd_data), .level(level), .empty(empty), .full(full),
    .overrun(overrun), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // one decoded frame, strobe held for one cycle
  task automatic frame(input logic [15:0] s, input logic v, input logic t);
    frm_sample = s; frm_valid = v; rate_tick = t; frm_done = 1'b1;
    @(negedge clk);
    frm_done = 1'b0; frm_valid = 1'b0; rate_tick = 1'b0;
  endtask

  task automatic tick();
    rate_tick = 1'b1;
    @(negedge clk);
    rate_tick = 1'b0;
  endtask

  task automatic pop_expect(input string req, input int exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk_eq(req, int'(rd_data), exp);
  endtask

  task automatic t_reset();
    chk_eq("R1 level", int'(level), 0);
    chk_eq("R1 empty", int'(empty), 1);
    chk_eq("R1 full", int'(full), 0);
    chk_eq("R1 flags", int'({overrun, underrun}), 0);
    chk_eq("R1 rd_data", int'(rd_data), 0);
  endtask

  task automatic t_valid_mode();
    mode_sel = 1'b0; chan_en = 1'b1;
    @(negedge clk);
    frame(16'hA001, 1'b1, 1'b0);
    frame(16'hA002, 1'b0, 1'b1);   // R2: invalid frame ignored even with tick
    frame(16'hA003, 1'b1, 1'b0);
    chk_eq("R2 level after mixed frames", int'(level), 2);
    pop_expect("R2 first sample", 16'hA001);
    pop_expect("R2 second sample", 16'hA003);
    chk_eq("R6 empty after drain", int'(empty), 1);
  endtask

  task automatic t_disabled();
    chan_en = 1'b0; mode_sel = 1'b0;
    @(negedge clk);
    frame(16'hD0D0, 1'b1, 1'b0);
    chk_eq("R3 no capture while disabled", int'(level), 0);
  endtask

  task automatic t_rate_mode();
    mode_sel = 1'b1; chan_en = 1'b1;
    @(negedge clk);
    tick();                          // R4: tick before first sample ignored
    frame(16'hB0FF, 1'b0, 1'b0);
    chk_eq("R4 invalid first frame", int'(level), 0);
    frame(16'hB000, 1'b1, 1'b0);
    chk_eq("R4 first valid frame stored", int'(level), 1);
    frame(16'hBEEF, 1'b1, 1'b0);     // R5: valid flag ignored now
    chk_eq("R5 valid without tick", int'(level), 1);
    tick();
    frame(16'hB001, 1'b0, 1'b0);
    chk_eq("R5 tick then invalid frame", int'(level), 2);
    tick(); tick();
    frame(16'hB002, 1'b1, 1'b0);
    frame(16'hB0EE, 1'b1, 1'b0);
    chk_eq("R5 two ticks one capture", int'(level), 3);
    frame(16'hB003, 1'b0, 1'b1);
    chk_eq("R5 same-cycle tick", int'(level), 4);
    pop_expect("R5 order 0", 16'hB000);
    pop_expect("R5 order 1", 16'hB001);
    pop_expect("R5 order 2", 16'hB002);
    pop_expect("R5 order 3", 16'hB003);
    // R3: re-enable restores the first-sample gate
    chan_en = 1'b0;
    @(negedge clk);
    chan_en = 1'b1;
    @(negedge clk);
    frame(16'hC0FF, 1'b0, 1'b1);
    chk_eq("R3 gate restored after re-enable", int'(level), 0);
    frame(16'hC000, 1'b1, 1'b0);
    chk_eq("R3 first valid after re-enable", int'(level), 1);
    pop_expect("R3 sample after re-enable", 16'hC000);
  endtask

  task automatic t_overflow();
    mode_sel = 1'b0; chan_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) frame(16'h5000 + 16'(i), 1'b1, 1'b0);
    chk_eq("R6 level at capacity", int'(level), 8);
    chk_eq("R6 full at capacity", int'(full), 1);
    chk_eq("R7 no overrun yet", int'(overrun), 0);
    frame(16'h5EEE, 1'b1, 1'b0);
    chk_eq("R7 overrun after drop", int'(overrun), 1);
    chk_eq("R7 level unchanged", int'(level), 8);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk_eq("R7 overrun cleared", int'(overrun), 0);
    ovr_clr = 1'b1;
    frame(16'h5EEF, 1'b1, 1'b0);     // drop and clear together
    ovr_clr = 1'b0;
    chk_eq("R7 set wins over clear", int'(overrun), 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    for (int i = 0; i < 8; i++) pop_expect("R7 stored data intact", 16'h5000 + i);
    chk_eq("R6 empty after drain", int'(empty), 1);
  endtask

  task automatic t_underrun();
    chk_eq("R8 no underrun yet", int'(underrun), 0);
    pop_expect("R8 rd_data held on empty read", 16'h5007);
    chk_eq("R8 underrun set", int'(underrun), 1);
    chk_eq("R8 level stays 0", int'(level), 0);
    udr_clr = 1'b1;
    @(negedge clk);
    udr_clr = 1'b0;
    chk_eq("R8 underrun cleared", int'(underrun), 0);
  endtask

  initial begin
    rst_n = 1'b0; frm_done = 1'b0; frm_valid = 1'b0; frm_sample = '0;
    chan_en = 1'b0; mode_sel = 1'b0; rate_tick = 1'b0;
    rd_en = 1'b0; ovr_clr = 1'b0; udr_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_valid_mode();
    t_disabled();
    t_rate_mode();
    t_overflow();
    t_underrun();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule